// File: doc/BRIEF.md
# Block-Transfer Serial Master with Inter-Byte Interval

This block is an 8-bit synchronous serial master. It moves a block of bytes between a small internal buffer and the serial lines with no CPU work for each byte. Software loads bytes into the buffer and sets the block length, the mode and the inter-byte interval. It then writes the start bit. The engine fetches each byte and shifts it out on `so_o` while it shifts a byte in from `si_i`. It writes the received byte back over the location it sent from. It then waits out an interval before it starts the next byte.

The interval has two forms. The fixed form is always two serial clock periods. The extended form lasts for the programmed number of periods, or until the CPU side reports that its buffer access is finished on `cpu_ack_i`, whichever takes longer. In single mode the block runs once and raises an interrupt pulse at its end. In repeat mode the buffer is sent over and over with no interrupt, until software asks for a stop.

Top module: `atx_spi_master`

## Requirements
- R1: `sck_o` idles high and has a period of 4 clocks: 2 clocks low, then 2 clocks high. `so_o` changes only on the clock edge where `sck_o` falls. `si_i` is sampled where `sck_o` rises. Each byte is sent and received bit 7 first.
- R2: Register address 0, bits [4:0], sets the block length: values 1 to 31 give that many bytes, and 0 gives 32. Bytes are taken from buffer addresses 0, 1, 2 and upward, and `busy_o` is high from the clock after the start write until the block ends.
- R3: The received byte is written into the buffer address its transmitted byte came from. The CPU read port shows the old byte in the clock of the eighth `sck_o` rise and the new byte one clock later.
- R4: Register address 2, bit 7 = 0 selects the fixed interval. The first `sck_o` rise of the next byte comes 12 clocks after the eighth rise of the previous byte. Bits [6:0] and `cpu_ack_i` have no effect.
- R5: Register address 2, bit 7 = 1 selects the extended interval, with N = max(2, bits [6:0]). Let k be the clock edge, counted after the eighth rise, at which `cpu_ack_i` is first sampled high (k >= 2). The next first rise comes 4 + max(4N, k) clocks after the eighth rise.
- R6: In single mode (register address 1, bit 0 = 0), `irq_o` is high for exactly one clock, starting one clock after the eighth rise of the last byte. `busy_o` falls in that same clock.
- R7: In repeat mode (register address 1, bit 0 = 1), the buffer address wraps from length-1 back to 0. The received data written back by earlier bytes is sent again, and `irq_o` never rises.
- R8: Writing 1 to register address 3, bit 1 while busy ends the transfer after the current byte. `busy_o` falls one clock after that byte's eighth rise.
- R9: While busy, a start (register address 3, bit 0) and any write to register addresses 0 to 2 are ignored. The running block keeps its length, its mode and its interrupt behaviour.
- R10: After reset, `sck_o` = 1, `so_o` = 1, `busy_o` = 0 and `irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 length, 1 mode, 2 interval, 3 control |
| cfg_wdata_i | input | 8 | Register write data |
| buf_we_i | input | 1 | CPU buffer write strobe |
| buf_addr_i | input | 5 | CPU buffer address |
| buf_wdata_i | input | 8 | CPU buffer write data |
| buf_rdata_o | output | 8 | CPU buffer read data, combinational |
| cpu_ack_i | input | 1 | CPU-side buffer access finished |
| sck_o | output | 1 | Serial clock |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |
| irq_o | output | 1 | End-of-block interrupt pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench measures every gap between the eighth rise of one byte and the first rise of the next, in clocks. It sweeps the programmed interval values below, at and above the minimum of two. It also covers the fixed mode with a large ignored value and a held-low acknowledge, and an acknowledge that arrives later and earlier than the programmed gap. A wrong offset, a missing clamp or a forgotten acknowledge therefore shows up as a gap several clocks off. At every byte end the buffer location is read in two clocks, so a write-back that lands one clock early or late, or at the wrong address, is reported. The lengths 1 and 32 (encoded as 0), the wrap in repeat mode and a stop in the middle of a block catch an off-by-one end test or an address that fails to wrap. The bench also counts interrupts and checks the busy flag at each byte end, and it changes the length and mode during a block, which exposes an interrupt raised in repeat mode or a register that does not hold while busy.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int REG_W   = 8;
  localparam int GAP_W   = REG_W - 1;
  localparam int SCK_DIV = 4;
  localparam int PH_W    = $clog2(SCK_DIV);
  localparam logic [PH_W-1:0] PH_FALL = '0;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(SCK_DIV / 2);
  localparam int MIN_GAP = 2;

  localparam logic [1:0] REG_LEN  = 2'd0;
  localparam logic [1:0] REG_MODE = 2'd1;
  localparam logic [1:0] REG_GAP  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_GAP
  } atx_state_e;
endpackage

// File: rtl/atx_cfg.sv
module atx_cfg
  import atx_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic [AW-1:0]    last_idx_o,
  output logic             repeat_o,
  output logic             ext_gap_o,
  output logic [GAP_W-1:0] gap_val_o,
  output logic             start_o,
  output logic             stop_o
);
  logic [AW-1:0]    len_q;
  logic             repeat_q;
  logic             ext_q;
  logic [GAP_W-1:0] gap_q;
  logic             cfg_wr;

  assign cfg_wr = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= AW'(1);
      repeat_q <= 1'b0;
      ext_q    <= 1'b0;
      gap_q    <= '0;
    end else if (cfg_wr) begin
      if (addr_i == REG_LEN)  len_q    <= wdata_i[AW-1:0];
      if (addr_i == REG_MODE) repeat_q <= wdata_i[0];
      if (addr_i == REG_GAP) begin
        ext_q <= wdata_i[REG_W-1];
        gap_q <= wdata_i[GAP_W-1:0];
      end
    end
  end

  // length 0 wraps to the full depth
  assign last_idx_o = len_q - AW'(1);
  assign repeat_o   = repeat_q;
  assign ext_gap_o  = ext_q;
  assign gap_val_o  = gap_q;
  assign start_o    = we_i && (addr_i == REG_CTRL) && wdata_i[0] && !busy_i;
  assign stop_o     = we_i && (addr_i == REG_CTRL) && wdata_i[1] && busy_i;
endmodule

// File: rtl/atx_buf.sv
module atx_buf #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [DW-1:0] eng_wdata_i,
  output logic [DW-1:0] eng_rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic          cpu_blocked;

  // engine write-back wins a same-address collision
  assign cpu_blocked = eng_we_i && (eng_addr_i == cpu_addr_i);

  always_ff @(posedge clk_i) begin
    if (eng_we_i) mem_q[eng_addr_i] <= eng_wdata_i;
    if (cpu_we_i && !cpu_blocked) mem_q[cpu_addr_i] <= cpu_wdata_i;
  end

  assign cpu_rdata_o = mem_q[cpu_addr_i];
  assign eng_rdata_o = mem_q[eng_addr_i];
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
  import atx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          si_i,
  output logic          sck_o,
  output logic          so_o,
  output logic [DW-1:0] rx_o,
  output logic          done_o
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [PH_W-1:0] phase_q;
  logic [BW-1:0]   bit_q;
  logic            run_q;
  logic            sck_q;
  logic            so_q;
  logic            done_q;
  logic [DW-1:0]   tx_q;
  logic [DW-1:0]   rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= '0;
      run_q   <= 1'b0;
      sck_q   <= 1'b1;
      so_q    <= 1'b1;
      done_q  <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        tx_q    <= load_data_i;
        run_q   <= 1'b1;
        phase_q <= '0;
        bit_q   <= '0;
      end else if (run_q) begin
        phase_q <= phase_q + PH_W'(1);
        if (phase_q == PH_FALL) begin
          sck_q <= 1'b0;
          so_q  <= tx_q[DW-1];
        end else if (phase_q == PH_RISE) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[DW-2:0], si_i};
          tx_q  <= {tx_q[DW-2:0], 1'b0};
          bit_q <= bit_q + BW'(1);
          if (bit_q == LAST_BIT) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign so_o   = so_q;
  assign rx_o   = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/atx_gap_timer.sv
module atx_gap_timer
  import atx_pkg::*;
#(
  parameter int GW = GAP_W,
  parameter int CW = GAP_W + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          ext_i,
  input  logic [GW-1:0] gap_val_i,
  input  logic          ack_i,
  output logic          done_o
);
  logic [GW-1:0] periods;
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt_q;
  logic          ack_q;

  always_comb begin
    periods = (ext_i && (gap_val_i > GW'(MIN_GAP))) ? gap_val_i : GW'(MIN_GAP);
    // clear lands one clock after the last rise, fetch adds one more
    limit   = CW'(periods) * CW'(SCK_DIV) - CW'(2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (run_i) begin
      if (cnt_q != '1) cnt_q <= cnt_q + CW'(1);
      ack_q <= ack_q | ack_i;
    end
  end

  assign done_o = (cnt_q >= limit) && (!ext_i || ack_q || ack_i);
endmodule

// File: rtl/atx_spi_master.sv
module atx_spi_master
  import atx_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [DW-1:0] buf_wdata_i,
  output logic [DW-1:0] buf_rdata_o,
  input  logic          cpu_ack_i,
  output logic          sck_o,
  output logic          so_o,
  input  logic          si_i,
  output logic          irq_o,
  output logic          busy_o
);
  atx_state_e       state_q;
  logic [AW-1:0]    idx_q;
  logic [AW-1:0]    last_idx;
  logic             busy_q;
  logic             irq_q;
  logic             stop_q;
  logic             cfg_repeat;
  logic             cfg_ext;
  logic [GAP_W-1:0] cfg_gap;
  logic             start_p;
  logic             stop_p;
  logic [DW-1:0]    tx_byte;
  logic [DW-1:0]    rx_byte;
  logic             sh_done;
  logic             gap_done;
  logic             load;
  logic             wb;
  logic             at_last;
  logic             end_now;

  atx_cfg #(.AW(AW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .busy_i     (busy_q),
    .last_idx_o (last_idx),
    .repeat_o   (cfg_repeat),
    .ext_gap_o  (cfg_ext),
    .gap_val_o  (cfg_gap),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  atx_buf #(.AW(AW), .DW(DW)) u_buf (
    .clk_i       (clk_i),
    .cpu_we_i    (buf_we_i),
    .cpu_addr_i  (buf_addr_i),
    .cpu_wdata_i (buf_wdata_i),
    .cpu_rdata_o (buf_rdata_o),
    .eng_we_i    (wb),
    .eng_addr_i  (idx_q),
    .eng_wdata_i (rx_byte),
    .eng_rdata_o (tx_byte)
  );

  atx_shifter #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_byte),
    .si_i        (si_i),
    .sck_o       (sck_o),
    .so_o        (so_o),
    .rx_o        (rx_byte),
    .done_o      (sh_done)
  );

  atx_gap_timer u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (wb),
    .run_i     (state_q == ST_GAP),
    .ext_i     (cfg_ext),
    .gap_val_i (cfg_gap),
    .ack_i     (cpu_ack_i),
    .done_o    (gap_done)
  );

  assign load    = (state_q == ST_FETCH);
  assign wb      = (state_q == ST_XFER) && sh_done;
  assign at_last = (idx_q == last_idx);
  assign end_now = stop_q || stop_p || (!cfg_repeat && at_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_p) stop_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_p) begin
            idx_q   <= '0;
            busy_q  <= 1'b1;
            stop_q  <= 1'b0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_XFER;
        ST_XFER: begin
          if (sh_done) begin
            if (end_now) begin
              busy_q  <= 1'b0;
              stop_q  <= 1'b0;
              irq_q   <= !cfg_repeat && at_last;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= at_last ? '0 : idx_q + AW'(1);
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_done) state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_o  = irq_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/atx_spi_master_chk.sv
module atx_spi_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_i,
  input logic so_i,
  input logic busy_i,
  input logic irq_i,
  input logic repeat_i
);
  p_sck_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_i);

  p_so_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(so_i) |-> $fell(sck_i));

  p_sck_low_two_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_i) |=> !sck_i);

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  p_irq_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (!busy_i && $past(busy_i)));

  p_no_irq_repeat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> !repeat_i);
endmodule

bind atx_spi_master atx_spi_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_i    (sck_o),
  .so_i     (so_o),
  .busy_i   (busy_o),
  .irq_i    (irq_o),
  .repeat_i (cfg_repeat)
);

// File: tb/tb_atx_spi_master.sv
module tb_atx_spi_master;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_addr_i = '0;
  logic [7:0]    cfg_wdata_i = '0;
  logic          buf_we_i = 1'b0;
  logic [AW-1:0] buf_addr_i;
  logic [7:0]    buf_wdata_i = '0;
  logic [7:0]    buf_rdata_o;
  logic          cpu_ack_i;
  logic          sck_o, so_o, irq_o, busy_o;
  logic          si_q = 1'b0;
  logic          ack_q = 1'b0;

  always #5 clk_i = ~clk_i;

  atx_spi_master dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .buf_we_i(buf_we_i), .buf_addr_i(buf_addr_i),
    .buf_wdata_i(buf_wdata_i), .buf_rdata_o(buf_rdata_o), .cpu_ack_i(cpu_ack_i),
    .sck_o(sck_o), .so_o(so_o), .si_i(si_q), .irq_o(irq_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // test configuration, written only by the stimulus process
  logic [7:0]    init_mem [DEPTH];
  logic [AW-1:0] init_addr = '0;
  bit            mon_en = 1'b0;
  bit            rep_mode = 1'b0;
  int            run_cnt = 1, exp_gap = 12, exp_bytes = 1, ack_mode = 0, ack_k = 0;
  string         gap_req = "R4", end_req = "R6";

  // monitor state, written only by the monitor
  int            byte_no, rise_in_byte, since_rise, irq_seen, cur_idx, cycles;
  bit            prev_sck, pending;
  logic [7:0]    tx_cap;
  logic [AW-1:0] mon_addr;

  assign buf_addr_i = mon_en ? mon_addr : init_addr;
  assign cpu_ack_i  = (ack_mode == 1) ? 1'b1 : ack_q;

  function automatic logic [7:0] sbyte(input int n);
    return 8'(n * 37 + 11);
  endfunction
  function automatic logic [7:0] tbyte(input int a, input int seed);
    return 8'(a * 13 + seed * 29 + 3);
  endfunction
  // what byte n of the run sends: initial content on the first pass, received data after
  function automatic logic [7:0] exp_tx(input int n);
    return (n < run_cnt) ? init_mem[n % run_cnt] : sbyte(n - run_cnt);
  endfunction

  initial begin
    cycles = 0;
    byte_no = 0; rise_in_byte = 0; since_rise = 0; irq_seen = 0; cur_idx = 0;
    prev_sck = 1'b1; pending = 1'b0; tx_cap = '0; mon_addr = '0;
  end

  always @(negedge clk_i) begin
    logic [7:0] sb;
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
    if (mon_en) begin
      if (irq_o) irq_seen++;
      if (sck_o && !prev_sck) begin
        if (rise_in_byte == 0) begin
          if (byte_no > 0) chk(since_rise + 1 == exp_gap, gap_req, since_rise + 1, exp_gap);
          ack_q = 1'b0;
          cur_idx = byte_no % run_cnt;
          mon_addr = AW'(cur_idx);
        end
        tx_cap = {tx_cap[6:0], so_o};
        if (rise_in_byte == 7) begin
          chk(tx_cap == exp_tx(byte_no), "R1 tx byte msb first", tx_cap, exp_tx(byte_no));
          chk(buf_rdata_o == exp_tx(byte_no), "R3 old byte at eighth rise",
              buf_rdata_o, exp_tx(byte_no));
          pending = 1'b1;
          rise_in_byte = 0;
          byte_no++;
        end else begin
          rise_in_byte++;
        end
        since_rise = 0;
      end else begin
        since_rise++;
        if (!sck_o && prev_sck) begin
          sb = sbyte(byte_no);
          si_q = sb[3'(7 - rise_in_byte)];
        end
        if (pending && since_rise == 1) begin
          chk(buf_rdata_o == sbyte(byte_no - 1), "R3 write-back", buf_rdata_o, sbyte(byte_no - 1));
          chk(busy_o == (byte_no != exp_bytes), end_req, busy_o, byte_no != exp_bytes);
          chk(irq_o == (!rep_mode && byte_no == exp_bytes), "R6 irq timing", irq_o,
              !rep_mode && byte_no == exp_bytes);
          pending = 1'b0;
        end
        if (ack_mode == 2 && byte_no > 0 && rise_in_byte == 0 && since_rise == ack_k) ack_q = 1'b1;
      end
      prev_sck = sck_o;
    end else begin
      byte_no = 0; rise_in_byte = 0; since_rise = 0; irq_seen = 0;
      prev_sck = 1'b1; pending = 1'b0; ack_q = 1'b0; si_q = 1'b0;
    end
  end

  task automatic wr_cfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk_i);
      init_mem[a] = tbyte(a, seed);
      buf_we_i = 1'b1; init_addr = AW'(a); buf_wdata_i = init_mem[a];
    end
    @(negedge clk_i);
    buf_we_i = 1'b0;
  endtask

  task automatic begin_block(input int len_field, input bit rep, input logic [7:0] ival,
                             input int am, input int k, input int gap, input int nbytes,
                             input int seed, input string greq, input string ereq);
    fill(seed);
    run_cnt = (len_field == 0) ? DEPTH : len_field;
    rep_mode = rep; exp_gap = gap; exp_bytes = nbytes;
    ack_mode = am; ack_k = k; gap_req = greq; end_req = ereq;
    wr_cfg(2'd0, 8'(len_field));
    wr_cfg(2'd1, {7'd0, rep});
    wr_cfg(2'd2, ival);
    mon_en = 1'b1;
    wr_cfg(2'd3, 8'h01);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
  endtask

  task automatic end_block(input string req);
    int t = 0;
    while (busy_o && t < 40000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (4) @(negedge clk_i);
    chk(!busy_o && sck_o, "R2 idle at end", busy_o, 0);
    chk(byte_no == exp_bytes, req, byte_no, exp_bytes);
    chk(irq_seen == (rep_mode ? 0 : 1), rep_mode ? "R7 no irq" : "R6 one irq",
        irq_seen, rep_mode ? 0 : 1);
    mon_en = 1'b0;
    ack_mode = 0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sck_o == 1'b1 && so_o == 1'b1, "R10 serial idle", {sck_o, so_o}, 3);
    chk(busy_o == 1'b0 && irq_o == 1'b0, "R10 flags clear", {busy_o, irq_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sck_o == 1'b1 && busy_o == 1'b0, "R10 after release", {sck_o, busy_o}, 2);

    // R4: fixed interval, large field value and held-low ack are ignored
    begin_block(4, 1'b0, 8'h1E, 0, 0, 12, 4, 1, "R4 fixed gap", "R6 busy at byte end");
    end_block("R2 length 4");

    // R5: extended interval sweep with ack tied high
    foreach (gap_list[i]) begin
      int g = gap_list[i];
      int n = (g > 2) ? g : 2;
      begin_block((i % 4) + 2, 1'b0, 8'(8'h80 | g), 1, 0, 4 * n + 4, (i % 4) + 2, i + 2,
                  "R5 extended gap", "R6 busy at byte end");
      end_block("R2 length sweep");
    end

    // R5: ack later than the programmed gap, then earlier
    begin_block(3, 1'b0, 8'h82, 2, 19, 24, 3, 11, "R5 late ack", "R6 busy at byte end");
    end_block("R2 length 3");
    begin_block(3, 1'b0, 8'h86, 2, 3, 28, 3, 12, "R5 early ack", "R6 busy at byte end");
    end_block("R2 length 3");

    // R2: boundary lengths, 0 encodes the full depth
    begin_block(0, 1'b0, 8'h00, 0, 0, 12, DEPTH, 13, "R4 fixed gap", "R6 busy at byte end");
    end_block("R2 length 0 means 32");
    begin_block(1, 1'b0, 8'h00, 0, 0, 12, 1, 14, "R4 fixed gap", "R6 busy at byte end");
    end_block("R2 length 1");

    // R7 and R8: repeat with wrap, stop during the seventh byte
    begin_block(3, 1'b1, 8'h00, 0, 0, 12, 7, 15, "R4 fixed gap", "R8 busy at stop");
    wait (byte_no == 6 && rise_in_byte == 2);
    wr_cfg(2'd3, 8'h02);
    end_block("R8 stop after current byte");

    // R9: length, mode and start writes while busy are ignored
    begin_block(3, 1'b0, 8'h00, 0, 0, 12, 3, 16, "R4 fixed gap", "R9 busy with ignored writes");
    wait (byte_no == 1);
    wr_cfg(2'd0, 8'd10);
    wr_cfg(2'd1, 8'h01);
    wr_cfg(2'd3, 8'h01);
    end_block("R9 length held while busy");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int gap_list [6] = '{0, 1, 2, 3, 5, 9};
endmodule